// File: doc/BRIEF.md
# Direct-Mapped Virtual Cache Controller

This block fronts a unified instruction and data cache. The cache holds 32 KB in 2048 lines of 16 bytes and is indexed by the logical address. Every address has exactly one line it can live in. Each line keeps a key in a key array, a valid flag, and four 32-bit words in a separate data array. A read compares the stored key with the upper address bits and the current privilege mode. It hands back the word only when the translation unit reports the access as satisfied, or when translation is switched off.

On a miss the block requests a four-word burst from the memory bus. The words arrive in order from the first word of the line. The block assembles the line, installs it, and then returns the requested word. A CPU write to a resident line drops that line. A separate input drops every line at once.

The CPU side uses word addresses (byte address bits 31:2). The bus side receives the line base as a byte address.

Top module: `vcache_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `bus_req` and `busy` are low and every line is invalid, so the first read of any address misses.
- R2: For a byte address A, the line index is A[14:4], the word within the line is A[3:2], and the stored key is {privilege bit, A[31:15]} (18 bits).
- R3: A read accepted at clock edge k (`cpu_req` high, `busy` low) that hits, with `mmu_ok` or `mmu_off` high, raises `rd_valid` for exactly one cycle after edge k+2 and shows the addressed word on `rd_data`. `bus_req` stays low throughout.
- R4: A hit while both `mmu_ok` and `mmu_off` are low returns nothing and does not start a bus request. The block holds until one of them is high, and `rd_valid` follows on the next edge.
- R5: A read miss raises `bus_req` after edge k+2. `bus_addr` holds the line base (A[31:4] followed by four zero bits) until the refill ends.
- R6: Refill words are taken on the edges where `bus_valid` is high, in the order word 0, 1, 2, 3. After the edge that takes word 3, `bus_req` is low, the line is valid, and `rd_valid` pulses with the requested word.
- R7: A line filled in one privilege mode misses when the same address is read in the other mode.
- R8: Two addresses with the same index and different keys evict each other.
- R9: A write (`cpu_we` high with `cpu_req`) whose key matches the resident line invalidates that line. A write with a non-matching key leaves the line valid. A write never raises `rd_valid` or `bus_req`, and `busy` is low again after edge k+2.
- R10: `inv_all` high at an edge invalidates every line. If it coincides with the edge that takes the last refill word, the new line also ends up invalid, but the requested word is still returned.
- R11: `busy` rises on the edge after a request is accepted and stays high until the block is idle again. `cpu_req` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken when `busy` is low |
| cpu_we | input | 1 | Request is a write (invalidate on match) |
| cpu_super | input | 1 | Privilege mode of the request, part of the key |
| cpu_addr | input | 30 | Word address (byte address bits 31:2) |
| mmu_ok | input | 1 | Translation unit reports the access satisfied |
| mmu_off | input | 1 | Translation is disabled |
| inv_all | input | 1 | Invalidate every line |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` carries the read result |
| rd_data | output | 32 | Returned word |
| busy | output | 1 | A request is in progress |
| bus_req | output | 1 | Line refill burst requested |
| bus_addr | output | 32 | Byte address of the line being refilled |
| bus_valid | input | 1 | A refill word is present on `bus_data` |
| bus_data | input | 32 | Refill word |

## Verification
A key, index or valid bit held in the wrong state shows up at the ports two edges after the read is accepted. A wrong hit skips `bus_req` and returns a stale word. A wrong miss raises `bus_req` where a pulse on `rd_valid` was due. A refill word stored in the wrong slot appears only when that word is requested, so reads return each word position of the lines they fill. A lost or spurious invalidation shows as a hit or miss flip on the next read of the affected line. Gating on the translation status is visible in the cycle the translation inputs change.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int LINES      = 2048;

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int BSEL_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int OFF_W      = BSEL_W + WSEL_W;
    localparam int IDX_W      = $clog2(LINES);
    localparam int WADDR_W    = ADDR_W - BSEL_W;
    localparam int KEY_W      = WADDR_W - IDX_W - WSEL_W + 1;
    localparam int LINE_W     = LINE_BYTES * 8;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WSEL_W-1:0]  wsel_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LINE_W-1:0]  line_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_CMP,
        ST_FILL
    } state_e;

    typedef struct packed {
        key_t  key;
        idx_t  idx;
        wsel_t wsel;
        logic  we;
    } req_t;

    function automatic key_t key_of(waddr_t a, logic sup);
        return {sup, a[WADDR_W-1:IDX_W+WSEL_W]};
    endfunction

    function automatic idx_t idx_of(waddr_t a);
        return a[IDX_W+WSEL_W-1:WSEL_W];
    endfunction

    function automatic wsel_t wsel_of(waddr_t a);
        return a[WSEL_W-1:0];
    endfunction

    function automatic word_t pick_word(line_t l, wsel_t w);
        word_t r;
        r = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (w == wsel_t'(i)) r = l[i*WORD_W +: WORD_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/vcache_tag_store.sv
module vcache_tag_store
    import vcache_pkg::*;
#(
    parameter int N_LINES = LINES
) (
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output key_t rd_key,
    output logic rd_vld,
    input  logic wr_set,
    input  logic wr_clr,
    input  idx_t wr_idx,
    input  key_t wr_key,
    input  logic clr_all
);

    key_t               key_mem [N_LINES];
    logic [N_LINES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_set) key_mem[wr_idx] <= wr_key;
        rd_key <= key_mem[rd_idx];
    end

    // Later assignments win: a full clear overrides a same-edge install.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (wr_set) vld_q[wr_idx] <= 1'b1;
            if (wr_clr) vld_q[wr_idx] <= 1'b0;
            if (clr_all) vld_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= vld_q[rd_idx];
    end

endmodule

// File: rtl/vcache_data_store.sv
module vcache_data_store
    import vcache_pkg::*;
#(
    parameter int N_LINES = LINES
) (
    input  logic  clk,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line
);

    line_t mem [N_LINES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_line;
        rd_line <= mem[rd_idx];
    end

endmodule

// File: rtl/vcache_fill.sv
module vcache_fill
    import vcache_pkg::*;
#(
    parameter int N_WORDS = WORDS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  beat_valid,
    input  word_t beat_data,
    output logic  last,
    output line_t line_out
);

    wsel_t cnt_q;
    word_t wbuf_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst || !active) cnt_q <= '0;
        else if (beat_valid) cnt_q <= cnt_q + wsel_t'(1);
    end

    always_ff @(posedge clk) begin
        if (active && beat_valid) wbuf_q[cnt_q] <= beat_data;
    end

    assign last = active && beat_valid && (cnt_q == wsel_t'(N_WORDS - 1));

    // The final beat is merged straight into the assembled line.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        assign line_out[g*WORD_W +: WORD_W] =
            (active && beat_valid && cnt_q == wsel_t'(g)) ? beat_data : wbuf_q[g];
    end

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
    import vcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_super,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic              mmu_ok,
    input  logic              mmu_off,
    input  logic              inv_all,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic [WORD_W-1:0] bus_data
);

    state_e st_q, st_d;
    req_t   req_q;
    key_t   rd_key;
    logic   rd_vld;
    line_t  rd_line;
    line_t  fill_line;
    logic   fill_last;
    logic   key_match;
    logic   mmu_pass;
    logic   clr_one;

    vcache_tag_store u_tags (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_q.idx),
        .rd_key  (rd_key),
        .rd_vld  (rd_vld),
        .wr_set  (fill_last),
        .wr_clr  (clr_one),
        .wr_idx  (req_q.idx),
        .wr_key  (req_q.key),
        .clr_all (inv_all)
    );

    vcache_data_store u_data (
        .clk     (clk),
        .rd_idx  (req_q.idx),
        .rd_line (rd_line),
        .wr_en   (fill_last),
        .wr_idx  (req_q.idx),
        .wr_line (fill_line)
    );

    vcache_fill u_fill (
        .clk        (clk),
        .rst        (rst),
        .active     (st_q == ST_FILL),
        .beat_valid (bus_valid),
        .beat_data  (bus_data),
        .last       (fill_last),
        .line_out   (fill_line)
    );

    assign key_match = rd_vld && (rd_key == req_q.key);
    assign mmu_pass  = mmu_ok || mmu_off;
    assign clr_one   = (st_q == ST_CMP) && req_q.we && key_match;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (cpu_req) st_d = ST_LOOK;
            ST_LOOK: st_d = ST_CMP;
            ST_CMP: begin
                if (req_q.we)      st_d = ST_IDLE;
                else if (!key_match) st_d = ST_FILL;
                else if (mmu_pass)   st_d = ST_IDLE;
            end
            ST_FILL: if (fill_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            req_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st_q     <= st_d;
            rd_valid <= 1'b0;
            if (st_q == ST_IDLE && cpu_req) begin
                req_q <= '{key:  key_of(cpu_addr, cpu_super),
                           idx:  idx_of(cpu_addr),
                           wsel: wsel_of(cpu_addr),
                           we:   cpu_we};
            end
            if (st_q == ST_CMP && !req_q.we && key_match && mmu_pass) begin
                rd_valid <= 1'b1;
                rd_data  <= pick_word(rd_line, req_q.wsel);
            end
            if (fill_last) begin
                rd_valid <= 1'b1;
                rd_data  <= pick_word(fill_line, req_q.wsel);
            end
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign bus_req  = (st_q == ST_FILL);
    assign bus_addr = {req_q.key[KEY_W-2:0], req_q.idx, OFF_W'(0)};

endmodule

// File: rtl/vcache_ctrl_chk.sv
module vcache_ctrl_chk
    import vcache_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              mmu_ok,
    input logic              mmu_off,
    input logic              rd_valid,
    input logic              busy,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !bus_req && !busy));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r4_hit_needs_mmu: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !$past(bus_req)) |-> $past(mmu_ok || mmu_off));

    a_r5_bus_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));

    a_r6_return_ends_bus: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !bus_req);

    a_r9_write_returns_nothing: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_req && cpu_we && !busy, 3) |-> !rd_valid);

    a_r11_busy_on_bus: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy);

    a_r11_accept: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !busy) |=> busy);

endmodule

bind vcache_ctrl vcache_ctrl_chk u_chk (.*);

// File: tb/vcache_ctrl_bench.sv
module vcache_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we, cpu_super;
    logic [29:0] cpu_addr;
    logic        mmu_ok, mmu_off, inv_all;
    logic        rd_valid, busy, bus_req, bus_valid;
    logic [31:0] rd_data, bus_addr, bus_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vcache_ctrl u_vcache_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_super(cpu_super), .cpu_addr(cpu_addr), .mmu_ok(mmu_ok),
        .mmu_off(mmu_off), .inv_all(inv_all), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_valid(bus_valid), .bus_data(bus_data)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        sup;
        logic        hit;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1230, 1'b0, 1'b0},  // R1 cold miss, index 0x123 (R2)
        '{32'h0000_1234, 1'b0, 1'b1},  // same line, word 1
        '{32'h0000_123C, 1'b0, 1'b1},  // same line, word 3
        '{32'h0000_1230, 1'b1, 1'b0},  // R7 other privilege mode
        '{32'h0000_1238, 1'b0, 1'b0},  // R7 evicted by the other mode
        '{32'h0000_9230, 1'b0, 1'b0},  // R8 same index, bit 15 set
        '{32'h0000_9234, 1'b0, 1'b1},
        '{32'h0000_1230, 1'b0, 1'b0},  // R8 evicted back
        '{32'h7FFF_FFFC, 1'b0, 1'b0},  // R2 top index, word 3
        '{32'h7FFF_FFF0, 1'b0, 1'b1},
        '{32'h0000_0008, 1'b1, 1'b0},  // R2 index 0
        '{32'h0000_0000, 1'b1, 1'b1},
        '{32'h8000_0004, 1'b0, 1'b0}   // R8 index 0, top key bit
    };

    function automatic logic [31:0] mword(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h3C3C_1234;
    endfunction

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_read(logic [31:0] a, logic sup, logic exp_hit, bit inv_last, string rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_super = sup; cpu_addr = a[31:2];
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (exp_hit) begin
            check(rq, "hit rd_valid", {31'b0, rd_valid}, 32'd1);
            check(rq, "hit rd_data", rd_data, mword(a));
            check(rq, "hit bus_req", {31'b0, bus_req}, 32'd0);
        end else begin
            check(rq, "miss rd_valid", {31'b0, rd_valid}, 32'd0);
            check("R5", "miss bus_req", {31'b0, bus_req}, 32'd1);
            check("R5", "bus_addr", bus_addr, {a[31:4], 4'h0});
            for (int w = 0; w < 4; w++) begin
                bus_valid = 1'b1;
                bus_data  = mword({a[31:4], 4'h0} + 32'(w * 4));
                if (w == 3 && inv_last) inv_all = 1'b1;
                @(negedge clk);
                bus_valid = 1'b0;
                inv_all   = 1'b0;
            end
            check("R6", "fill rd_valid", {31'b0, rd_valid}, 32'd1);
            check("R6", "fill rd_data", rd_data, mword(a));
            check("R6", "fill bus_req", {31'b0, bus_req}, 32'd0);
        end
    endtask

    task automatic do_write(logic [31:0] a, logic sup);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_super = sup; cpu_addr = a[31:2];
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", "write rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R9", "write bus_req", {31'b0, bus_req}, 32'd0);
        check("R9", "write busy", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_super = 1'b0;
        cpu_addr = '0; mmu_ok = 1'b1; mmu_off = 1'b0; inv_all = 1'b0;
        bus_valid = 1'b0; bus_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R1", "reset bus_req", {31'b0, bus_req}, 32'd0);
        check("R1", "reset busy", {31'b0, busy}, 32'd0);

        for (int i = 0; i < NV; i++)
            do_read(VECS[i].addr, VECS[i].sup, VECS[i].hit, 1'b0,
                    VECS[i].hit ? "R3" : "R5");

        // R3: translation disabled still lets a hit through
        mmu_ok = 1'b0; mmu_off = 1'b1;
        do_read(32'h0000_1234, 1'b0, 1'b1, 1'b0, "R3");
        mmu_off = 1'b0;

        // R4 and R11: hit held for translation, stray request ignored
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 30'(32'h0000_1238 >> 2); cpu_super = 1'b0;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R4", "held rd_valid", {31'b0, rd_valid}, 32'd0);
        check("R4", "held bus_req", {31'b0, bus_req}, 32'd0);
        check("R11", "held busy", {31'b0, busy}, 32'd1);
        cpu_req = 1'b1; cpu_addr = 30'(32'h0000_5550 >> 2);
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R4", "still held rd_valid", {31'b0, rd_valid}, 32'd0);
        mmu_ok = 1'b1;
        @(negedge clk);
        check("R4", "released rd_valid", {31'b0, rd_valid}, 32'd1);
        check("R11", "released rd_data", rd_data, mword(32'h0000_1238));
        @(negedge clk);
        check("R11", "idle after release", {31'b0, busy}, 32'd0);

        // R9: non-matching write leaves line; matching write drops it
        do_write(32'h0000_9238, 1'b0);
        do_read(32'h0000_1230, 1'b0, 1'b1, 1'b0, "R9");
        do_write(32'h0000_1234, 1'b0);
        do_read(32'h0000_123C, 1'b0, 1'b0, 1'b0, "R9");

        // R10: invalidate every line
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        do_read(32'h7FFF_FFF0, 1'b0, 1'b0, 1'b0, "R10");
        do_read(32'h0000_123C, 1'b0, 1'b0, 1'b0, "R10");

        // R10: invalidate on the edge of the last refill word
        do_read(32'h0000_2004, 1'b0, 1'b0, 1'b1, "R10");
        do_read(32'h0000_2004, 1'b0, 1'b0, 1'b0, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule